// File: doc/BRIEF.md
# Reset-Qualified Strap Capture Decoder

This block latches a set of board configuration straps, each at its own qualifying event. A resume-reset release, a platform power-good rise and a deep-sleep power-good rise each define a capture domain. The block brings every strap pin and every qualifier into the block clock through a two-flop synchronizer. It detects each qualifier's rising edge synchronously and stores the domain's straps at that edge. It holds them until the qualifier falls again. While a domain has not yet captured, it drives that domain's pull-enable output high so the weak on-die pulls set the default levels. Once the capture is done, the pull-enable is released.

The resume domain carries a 4-bit boot-location code, a crystal-frequency select and a group of reserved straps. The platform domain carries the boot-block swap strap, the watchdog-reboot suppression strap and one reserved strap. The deep-sleep domain carries one reserved strap. The boot code is decoded into a BIOS source, a firmware location and an eSPI enable. A reserved code, or a reserved strap seen at the wrong level, raises a sticky configuration error.

Top module: `strap_capture_decoder`

## Requirements
- R1: Strap pins and the three qualifiers each pass through two synchronizing flops. A domain's pull-enable output falls exactly 3 clock edges after its qualifier pin rises, and stays high through the second of those edges.
- R2: The straps of each domain are captured only at that domain's qualifier rising edge. Resume domain: boot code, crystal select, must-be-high reserved group, must-be-low reserved group. Platform domain: swap, no-reboot, must-be-low debug strap. Deep-sleep domain: one must-be-low strap.
- R3: The decoded outputs of a domain reflect the captured values 4 clock edges after its qualifier pin rises.
- R4: While a qualifier stays high, the domain's outputs do not change, whatever its strap pins do.
- R5: When a qualifier falls, its pull-enable output rises again 3 edges later. Its decoded outputs return to their defaults 4 edges later: bios_src 0, fw_remote 0, espi_en 1, xtal_24m 0, top_swap 0, no_reboot 0.
- R6: Boot code bit 0 is the LSB, and {bios_src, fw_remote, espi_en} decode as follows. 0000 gives {0,0,1}. 0010 gives {0,0,0}. 0100 gives {1,0,1}. 1000 gives {2,1,1}. 1100 gives {1,1,1}. bios_src 0 means local SPI, 1 means the eSPI peripheral channel, and 2 means eSPI-attached flash.
- R7: Any other boot code is reserved. It sets config_error and makes the boot outputs take the 0000 decode {0,0,1}.
- R8: A must-be-high resume strap captured low, or a must-be-low strap captured high in any domain, sets config_error. A resume-domain violation also forces the 0000 boot decode. The crystal select is not affected by the fallback.
- R9: config_error is sticky. It stays set across qualifier falls and recaptures, and only rst clears it.
- R10: xtal_24m is 1 when the captured crystal strap is 1 (24 MHz) and 0 when it is 0 (38.4 MHz).
- R11: top_swap and no_reboot equal the captured swap and no-reboot straps.
- R12: During and after rst, with all qualifiers low, every pull-enable is 1, config_error is 0 and the decoded outputs hold their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| rsm_rst_n | input | 1 | Resume reset, capture on release (rise) |
| plat_pwrok | input | 1 | Platform power-good, capture on rise |
| dsw_pwrok | input | 1 | Deep-sleep power-good, capture on rise |
| boot_pins | input | 4 | Boot-location code straps, bit 0 LSB |
| xtal_pin | input | 1 | Crystal frequency strap |
| rsv_hi_pins | input | RSV_HI_W | Resume-domain straps that must sample 1 |
| rsv_lo_pins | input | RSV_LO_W | Resume-domain straps that must sample 0 |
| swap_pin | input | 1 | Boot-block swap strap |
| noreboot_pin | input | 1 | Watchdog reboot suppression strap |
| dbg_pin | input | 1 | Platform-domain strap that must sample 0 |
| deep_pin | input | 1 | Deep-sleep-domain strap that must sample 0 |
| pull_en_rsm | output | 1 | Resume-domain pull enable |
| pull_en_plat | output | 1 | Platform-domain pull enable |
| pull_en_dsw | output | 1 | Deep-sleep-domain pull enable |
| bios_src | output | 2 | BIOS location |
| fw_remote | output | 1 | Firmware image on eSPI-attached flash |
| espi_en | output | 1 | eSPI enabled |
| xtal_24m | output | 1 | Crystal is 24 MHz |
| top_swap | output | 1 | Boot-block swap active |
| no_reboot | output | 1 | Watchdog reboot suppressed |
| config_error | output | 1 | Sticky configuration error |

## Verification
Each qualifier is raised or dropped on a falling clock edge, and the edges after it are counted on later falling edges. The pull-enable is checked at the second of those edges, where it is still unchanged, and at the third, where it has changed. The decoded outputs and config_error are checked at the fourth, when the output register has been loaded. Strap pins are set two cycles before a qualifier rises, so the synchronized pins are already stable when the capture happens. The bench expects hold behaviour over a six-cycle window, and all 16 boot codes and all reserved-group patterns are swept.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
  localparam int BOOT_W = 4;

  typedef enum logic [1:0] {
    BIOS_LOCAL_SPI   = 2'd0,
    BIOS_ESPI_PERIPH = 2'd1,
    BIOS_ESPI_FLASH  = 2'd2
  } bios_src_e;

  typedef struct packed {
    bios_src_e bios;
    logic      fw_remote;
    logic      espi_en;
  } boot_cfg_t;

  localparam boot_cfg_t BOOT_DEFAULT = '{bios: BIOS_LOCAL_SPI, fw_remote: 1'b0, espi_en: 1'b1};
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/capture_domain.sv
module capture_domain #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         qual,
  input  logic [W-1:0] pins,
  output logic [W-1:0] held,
  output logic         valid,
  output logic         pull_en
);
  logic qual_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      qual_d <= 1'b0;
      held   <= '0;
      valid  <= 1'b0;
    end else begin
      qual_d <= qual;
      if (!qual) begin
        held  <= '0;
        valid <= 1'b0;
      end else if (!qual_d) begin
        held  <= pins;
        valid <= 1'b1;
      end
    end
  end

  assign pull_en = ~valid;
endmodule

// File: rtl/boot_decode.sv
module boot_decode
  import strap_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [BOOT_W-1:0] code,
  input  logic              side_fault,
  output logic              code_rsv,
  output boot_cfg_t         cfg_q
);
  boot_cfg_t dec;
  logic      rsv_raw;

  always_comb begin
    rsv_raw = 1'b0;
    dec     = BOOT_DEFAULT;
    unique case (code)
      4'b0000: dec = '{bios: BIOS_LOCAL_SPI,   fw_remote: 1'b0, espi_en: 1'b1};
      4'b0010: dec = '{bios: BIOS_LOCAL_SPI,   fw_remote: 1'b0, espi_en: 1'b0};
      4'b0100: dec = '{bios: BIOS_ESPI_PERIPH, fw_remote: 1'b0, espi_en: 1'b1};
      4'b1000: dec = '{bios: BIOS_ESPI_FLASH,  fw_remote: 1'b1, espi_en: 1'b1};
      4'b1100: dec = '{bios: BIOS_ESPI_PERIPH, fw_remote: 1'b1, espi_en: 1'b1};
      default: rsv_raw = 1'b1;
    endcase
  end

  assign code_rsv = valid & rsv_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= BOOT_DEFAULT;
    end else if (!valid || code_rsv || side_fault) begin
      cfg_q <= BOOT_DEFAULT;
    end else begin
      cfg_q <= dec;
    end
  end
endmodule

// File: rtl/strap_capture_decoder.sv
module strap_capture_decoder
  import strap_cfg_pkg::*;
#(
  parameter int RSV_HI_W = 3,
  parameter int RSV_LO_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rsm_rst_n,
  input  logic                plat_pwrok,
  input  logic                dsw_pwrok,
  input  logic [3:0]          boot_pins,
  input  logic                xtal_pin,
  input  logic [RSV_HI_W-1:0] rsv_hi_pins,
  input  logic [RSV_LO_W-1:0] rsv_lo_pins,
  input  logic                swap_pin,
  input  logic                noreboot_pin,
  input  logic                dbg_pin,
  input  logic                deep_pin,
  output logic                pull_en_rsm,
  output logic                pull_en_plat,
  output logic                pull_en_dsw,
  output logic [1:0]          bios_src,
  output logic                fw_remote,
  output logic                espi_en,
  output logic                xtal_24m,
  output logic                top_swap,
  output logic                no_reboot,
  output logic                config_error
);
  localparam int N_DOM  = 3;
  localparam int RSM_W  = BOOT_W + 1 + RSV_HI_W + RSV_LO_W;
  localparam int PLAT_W = 3;
  localparam int DSW_W  = 1;

  // qualifier synchronizer: bit 0 resume, 1 platform, 2 deep-sleep
  logic [N_DOM-1:0] qual_s;
  strap_sync #(.W(N_DOM)) u_qsync (
    .clk(clk), .rst(rst), .d({dsw_pwrok, plat_pwrok, rsm_rst_n}), .q(qual_s)
  );

  logic [RSM_W-1:0]  rsm_s, rsm_h;
  logic [PLAT_W-1:0] plat_s, plat_h;
  logic [DSW_W-1:0]  dsw_s, dsw_h;
  logic              rsm_v, plat_v, dsw_v;

  strap_sync #(.W(RSM_W)) u_rsync (
    .clk(clk), .rst(rst), .d({boot_pins, xtal_pin, rsv_hi_pins, rsv_lo_pins}), .q(rsm_s)
  );
  strap_sync #(.W(PLAT_W)) u_psync (
    .clk(clk), .rst(rst), .d({swap_pin, noreboot_pin, dbg_pin}), .q(plat_s)
  );
  strap_sync #(.W(DSW_W)) u_dsync (
    .clk(clk), .rst(rst), .d(deep_pin), .q(dsw_s)
  );

  capture_domain #(.W(RSM_W)) u_rsm (
    .clk(clk), .rst(rst), .qual(qual_s[0]), .pins(rsm_s),
    .held(rsm_h), .valid(rsm_v), .pull_en(pull_en_rsm)
  );
  capture_domain #(.W(PLAT_W)) u_plat (
    .clk(clk), .rst(rst), .qual(qual_s[1]), .pins(plat_s),
    .held(plat_h), .valid(plat_v), .pull_en(pull_en_plat)
  );
  capture_domain #(.W(DSW_W)) u_dsw (
    .clk(clk), .rst(rst), .qual(qual_s[2]), .pins(dsw_s),
    .held(dsw_h), .valid(dsw_v), .pull_en(pull_en_dsw)
  );

  // resume field split
  logic [BOOT_W-1:0]   boot_h;
  logic                xtal_h;
  logic [RSV_HI_W-1:0] hi_h;
  logic [RSV_LO_W-1:0] lo_h;
  assign {boot_h, xtal_h, hi_h, lo_h} = rsm_h;

  logic rsm_side, plat_viol, dsw_viol, code_rsv;
  assign rsm_side  = rsm_v & ((hi_h != {RSV_HI_W{1'b1}}) | (lo_h != '0));
  assign plat_viol = plat_v & plat_h[0];
  assign dsw_viol  = dsw_v & dsw_h[0];

  boot_cfg_t cfg_q;
  boot_decode u_dec (
    .clk(clk), .rst(rst), .valid(rsm_v), .code(boot_h),
    .side_fault(rsm_side), .code_rsv(code_rsv), .cfg_q(cfg_q)
  );

  logic xtal_q, swap_q, nrb_q, err_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      xtal_q <= 1'b0;
      swap_q <= 1'b0;
      nrb_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      xtal_q <= rsm_v & xtal_h;
      swap_q <= plat_v & plat_h[2];
      nrb_q  <= plat_v & plat_h[1];
      err_q  <= err_q | code_rsv | rsm_side | plat_viol | dsw_viol;
    end
  end

  assign bios_src     = cfg_q.bios;
  assign fw_remote    = cfg_q.fw_remote;
  assign espi_en      = cfg_q.espi_en;
  assign xtal_24m     = xtal_q;
  assign top_swap     = swap_q;
  assign no_reboot    = nrb_q;
  assign config_error = err_q;
endmodule

// File: rtl/strap_capture_checker.sv
module strap_capture_checker (
  input logic       clk,
  input logic       rst,
  input logic       rsm_rst_n,
  input logic       plat_pwrok,
  input logic       dsw_pwrok,
  input logic       pull_en_rsm,
  input logic       pull_en_plat,
  input logic       pull_en_dsw,
  input logic [1:0] bios_src,
  input logic       fw_remote,
  input logic       espi_en,
  input logic       xtal_24m,
  input logic       top_swap,
  input logic       no_reboot,
  input logic       config_error
);
  a_r9_error_sticky: assert property (@(posedge clk) disable iff (rst)
    config_error |=> config_error);

  a_r1_rsm_release: assert property (@(posedge clk) disable iff (rst)
    $fell(pull_en_rsm) |-> $past(rsm_rst_n, 2));
  a_r1_plat_release: assert property (@(posedge clk) disable iff (rst)
    $fell(pull_en_plat) |-> $past(plat_pwrok, 2));
  a_r5_dsw_reassert: assert property (@(posedge clk) disable iff (rst)
    $rose(pull_en_dsw) |-> !$past(dsw_pwrok, 2));

  a_r4_plat_hold: assert property (@(posedge clk) disable iff (rst)
    (!pull_en_plat && $past(!pull_en_plat)) |=> ($stable(top_swap) && $stable(no_reboot)));
  a_r4_rsm_hold: assert property (@(posedge clk) disable iff (rst)
    (!pull_en_rsm && $past(!pull_en_rsm)) |=>
      ($stable(bios_src) && $stable(fw_remote) && $stable(espi_en) && $stable(xtal_24m)));

  a_r5_rsm_defaults: assert property (@(posedge clk) disable iff (rst)
    $past(pull_en_rsm) |-> (bios_src == 2'd0 && !fw_remote && espi_en && !xtal_24m));
  a_r5_plat_defaults: assert property (@(posedge clk) disable iff (rst)
    $past(pull_en_plat) |-> (!top_swap && !no_reboot));
endmodule

bind strap_capture_decoder strap_capture_checker u_chk (
  .clk(clk), .rst(rst), .rsm_rst_n(rsm_rst_n), .plat_pwrok(plat_pwrok),
  .dsw_pwrok(dsw_pwrok), .pull_en_rsm(pull_en_rsm), .pull_en_plat(pull_en_plat),
  .pull_en_dsw(pull_en_dsw), .bios_src(bios_src), .fw_remote(fw_remote),
  .espi_en(espi_en), .xtal_24m(xtal_24m), .top_swap(top_swap),
  .no_reboot(no_reboot), .config_error(config_error)
);

// File: tb/sim_strap_capture_decoder.sv
module sim_strap_capture_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int HI_W = 3;
  localparam int LO_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rsm_rst_n = 1'b0, plat_pwrok = 1'b0, dsw_pwrok = 1'b0;
  logic [3:0] boot_pins = '0;
  logic xtal_pin = 1'b0;
  logic [HI_W-1:0] rsv_hi_pins = '1;
  logic [LO_W-1:0] rsv_lo_pins = '0;
  logic swap_pin = 1'b0, noreboot_pin = 1'b0, dbg_pin = 1'b0, deep_pin = 1'b0;
  logic pull_en_rsm, pull_en_plat, pull_en_dsw;
  logic [1:0] bios_src;
  logic fw_remote, espi_en, xtal_24m, top_swap, no_reboot, config_error;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_capture_decoder #(.RSV_HI_W(HI_W), .RSV_LO_W(LO_W)) u0 (
    .clk(clk), .rst(rst), .rsm_rst_n(rsm_rst_n), .plat_pwrok(plat_pwrok),
    .dsw_pwrok(dsw_pwrok), .boot_pins(boot_pins), .xtal_pin(xtal_pin),
    .rsv_hi_pins(rsv_hi_pins), .rsv_lo_pins(rsv_lo_pins), .swap_pin(swap_pin),
    .noreboot_pin(noreboot_pin), .dbg_pin(dbg_pin), .deep_pin(deep_pin),
    .pull_en_rsm(pull_en_rsm), .pull_en_plat(pull_en_plat), .pull_en_dsw(pull_en_dsw),
    .bios_src(bios_src), .fw_remote(fw_remote), .espi_en(espi_en),
    .xtal_24m(xtal_24m), .top_swap(top_swap), .no_reboot(no_reboot),
    .config_error(config_error)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {bios_src, fw_remote, espi_en} expected for a boot code; bit 4 = reserved
  function automatic logic [4:0] exp_boot(input logic [3:0] c);
    logic ok;
    logic [1:0] b;
    ok = (c == 4'd0) || (c == 4'd2) || (c == 4'd4) || (c == 4'd8) || (c == 4'd12);
    if (!ok) return {1'b1, 2'd0, 1'b0, 1'b1};
    b = (c == 4'd8) ? 2'd2 : (c[2] ? 2'd1 : 2'd0);
    return {1'b0, b, c[3], (c != 4'd2)};
  endfunction

  task automatic apply_rst();
    @(negedge clk);
    rst = 1'b1; rsm_rst_n = 1'b0; plat_pwrok = 1'b0; dsw_pwrok = 1'b0;
    boot_pins = '0; xtal_pin = 1'b0; rsv_hi_pins = '1; rsv_lo_pins = '0;
    swap_pin = 1'b0; noreboot_pin = 1'b0; dbg_pin = 1'b0; deep_pin = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // raise resume qualifier and check release timing; leaves bench 4 edges after rise
  task automatic raise_rsm(input string tag);
    rsm_rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({tag, " R1 pull still on"}, {7'd0, pull_en_rsm}, 8'd1);
    @(negedge clk);
    chk({tag, " R1 pull released"}, {7'd0, pull_en_rsm}, 8'd0);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R12 reset state
    repeat (2) @(negedge clk);
    chk("R12 pulls in reset", {5'd0, pull_en_dsw, pull_en_plat, pull_en_rsm}, 8'h07);
    chk("R12 decode in reset", {2'd0, bios_src, fw_remote, espi_en, xtal_24m, config_error}, 8'h04);
    apply_rst();
    chk("R12 after reset", {bios_src, fw_remote, espi_en, xtal_24m, top_swap, no_reboot, config_error}, 8'h10);

    // R6 R7 R10: all 16 boot codes, crystal toggled
    for (int c = 0; c < 16; c++) begin
      logic [4:0] e;
      apply_rst();
      boot_pins = c[3:0];
      xtal_pin = c[0];
      repeat (2) @(negedge clk);
      raise_rsm("boot");
      e = exp_boot(c[3:0]);
      chk($sformatf("R6 R7 code %0d decode", c), {4'd0, bios_src, fw_remote, espi_en}, {4'd0, e[3:0]});
      chk($sformatf("R7 code %0d error", c), {7'd0, config_error}, {7'd0, e[4]});
      chk($sformatf("R10 code %0d crystal", c), {7'd0, xtal_24m}, {7'd0, c[0]});
    end

    // R8: must-be-high and must-be-low resume groups, valid code 0100
    for (int v = 0; v < (1 << (HI_W + LO_W)); v++) begin
      logic bad;
      apply_rst();
      boot_pins = 4'b0100;
      xtal_pin = 1'b1;
      {rsv_hi_pins, rsv_lo_pins} = v[HI_W+LO_W-1:0];
      bad = (v[HI_W+LO_W-1:LO_W] != {HI_W{1'b1}}) || (v[LO_W-1:0] != 0);
      repeat (2) @(negedge clk);
      raise_rsm("rsv");
      chk($sformatf("R8 pattern %0d error", v), {7'd0, config_error}, {7'd0, bad});
      chk($sformatf("R8 pattern %0d decode", v), {4'd0, bios_src, fw_remote, espi_en},
          bad ? 8'h01 : 8'h05);
      chk($sformatf("R8 pattern %0d crystal kept", v), {7'd0, xtal_24m}, 8'd1);
    end

    // R4 hold and R5 release of resume domain
    apply_rst();
    boot_pins = 4'b1000; xtal_pin = 1'b1;
    repeat (2) @(negedge clk);
    raise_rsm("hold");
    boot_pins = 4'b0010; xtal_pin = 1'b0; rsv_hi_pins = '0;
    repeat (6) @(negedge clk);
    chk("R4 resume held", {3'd0, bios_src, fw_remote, espi_en, xtal_24m}, {3'd0, 2'd2, 1'b1, 1'b1, 1'b1});
    chk("R4 no error from pin change", {7'd0, config_error}, 8'd0);
    rsm_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 pull still off", {7'd0, pull_en_rsm}, 8'd0);
    @(negedge clk);
    chk("R5 pull back on", {7'd0, pull_en_rsm}, 8'd1);
    @(negedge clk);
    chk("R5 resume defaults", {3'd0, bios_src, fw_remote, espi_en, xtal_24m}, 8'h02);

    // R2 R11: platform straps
    for (int s = 0; s < 4; s++) begin
      apply_rst();
      swap_pin = s[1]; noreboot_pin = s[0];
      repeat (2) @(negedge clk);
      plat_pwrok = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 plat pull still on", {7'd0, pull_en_plat}, 8'd1);
      @(negedge clk);
      chk("R1 plat pull released", {7'd0, pull_en_plat}, 8'd0);
      @(negedge clk);
      chk($sformatf("R11 plat %0d", s), {6'd0, top_swap, no_reboot}, {6'd0, s[1:0]});
      chk("R2 resume untouched", {6'd0, pull_en_rsm, pull_en_dsw}, 8'h03);
      swap_pin = ~s[1]; noreboot_pin = ~s[0];
      repeat (6) @(negedge clk);
      chk($sformatf("R4 plat %0d held", s), {6'd0, top_swap, no_reboot}, {6'd0, s[1:0]});
    end

    // R8 R9: platform debug strap violation is sticky
    apply_rst();
    dbg_pin = 1'b1; swap_pin = 1'b1;
    repeat (2) @(negedge clk);
    plat_pwrok = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 debug strap error", {7'd0, config_error}, 8'd1);
    dbg_pin = 1'b0;
    plat_pwrok = 1'b0;
    repeat (6) @(negedge clk);
    chk("R5 plat defaults", {6'd0, top_swap, no_reboot}, 8'd0);
    chk("R9 error survives qualifier fall", {7'd0, config_error}, 8'd1);
    plat_pwrok = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 error survives clean recapture", {7'd0, config_error}, 8'd1);
    apply_rst();
    chk("R9 rst clears error", {7'd0, config_error}, 8'd0);

    // R2 R8: deep-sleep strap
    for (int d = 0; d < 2; d++) begin
      apply_rst();
      deep_pin = d[0];
      repeat (2) @(negedge clk);
      dsw_pwrok = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 dsw pull still on", {7'd0, pull_en_dsw}, 8'd1);
      @(negedge clk);
      chk("R1 dsw pull released", {7'd0, pull_en_dsw}, 8'd0);
      @(negedge clk);
      chk($sformatf("R8 deep strap %0d", d), {7'd0, config_error}, {7'd0, d[0]});
      chk("R2 dsw leaves others", {6'd0, pull_en_rsm, pull_en_plat}, 8'h03);
    end

    // R3: resume capture while other domains already captured
    apply_rst();
    plat_pwrok = 1'b1; dsw_pwrok = 1'b1;
    boot_pins = 4'b1100;
    repeat (6) @(negedge clk);
    chk("R3 before resume capture", {4'd0, bios_src, fw_remote, espi_en}, 8'h01);
    raise_rsm("r3");
    chk("R3 decode after 4 edges", {4'd0, bios_src, fw_remote, espi_en}, 8'h07);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule